// File: doc/BRIEF.md
# Power Mode and Wakeup Controller

This block decides which clocks a small controller core receives. Software writes a two-bit mode code while the core runs. The block chooses among four operating states from that code:
- full-speed running;
- low-speed running, where the core clock is the low-speed source divided by four and the divider is picked downstream through a select output;
- a green idle state, where the core is gated but the low-speed oscillator keeps running;
- a sleep state, where both oscillators are stopped.

The block drives the enables of the high-speed and low-speed oscillators and the enable of the core clock gate. It runs on the oscillator clock.

Idle states are left on wakeup events. A falling edge on any enabled port pin wakes the block from either idle state. The pin is first brought into the clock domain through two flops. In the green state only, a timer timeout also wakes the block, provided the timer wakeup enable is set. Reset wakes it unconditionally.

Every wakeup is followed by a warm-up window. The window lasts a parameterised number of oscillator cycles, 2048 by default. During it the core clock stays gated while the oscillators of the earlier running mode restart. After the window the block returns to the running mode that was active before the idle request. Wakeup events that arrive inside the window are dropped.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the block is in full-speed running: cpu_clk_en=1, hosc_en=1, losc_en=1, lo_clk_sel=0.
- R2: A mode_wr pulse with cpu_clk_en=1 takes mode_bits as the new mode, encoded 00 full-speed, 10 low-speed, 01 sleep, 11 green. Low-speed gives hosc_en=0, losc_en=1, lo_clk_sel=1, cpu_clk_en=1. Full-speed gives hosc_en=1, losc_en=1, lo_clk_sel=0, cpu_clk_en=1. The change shows after the clock edge that samples the write.
- R3: Sleep drives cpu_clk_en=0, hosc_en=0 and losc_en=0.
- R4: Green drives cpu_clk_en=0 and losc_en=1. hosc_en keeps the value of the running mode it came from, and so does lo_clk_sel.
- R5: In sleep, only a falling edge of an enabled pin wakes the block. A timer timeout is ignored there even when tmr_wake_en=1.
- R6: In green, a timer timeout wakes the block only when tmr_wake_en=1. An enabled pin falling edge also wakes it.
- R7: After a wakeup, cpu_clk_en stays 0 for WARM_CYC cycles. During that time losc_en=1 and hosc_en follows the earlier running mode. The block then resumes that mode. cpu_clk_en first reads 1 after the WARM_CYC+3rd clock edge counted from a pin falling, and after the WARM_CYC+1st edge counted from the timeout pulse.
- R8: Wakeup events inside the warm-up window are neither acted on nor queued. The window neither restarts nor lengthens, and no second window follows.
- R9: A mode_wr while cpu_clk_en=0 (sleep, green or warm-up) is ignored.
- R10: A pin whose pin_wake_mask bit is 0 never wakes the block. A rising edge on a pin never wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, also a wakeup |
| mode_wr | input | 1 | Mode code write strobe |
| mode_bits | input | 2 | Mode code: 00 full, 10 low-speed, 01 sleep, 11 green |
| tmr_wake_en | input | 1 | Allows the timer timeout to wake from green |
| tmr_timeout | input | 1 | Timer timeout pulse, clk domain |
| pin_in | input | NPINS | Port pin levels, asynchronous |
| pin_wake_mask | input | NPINS | Per-pin wakeup enable |
| cpu_clk_en | output | 1 | Core clock gate enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| lo_clk_sel | output | 1 | 1 selects low-speed clock divided by four |

## Verification
The bench times the warm-up exactly from a pin falling and from a timer pulse. A design with an off-by-one in the counter, or with one synchronizer stage missing or extra, shows the core clock one edge early or late.

A timer timeout in sleep is applied with tmr_wake_en=1. A timer timeout in green is applied with tmr_wake_en=0. Masked pins and rising pin edges are also applied. A design that merged the wake sources of the two idle states would leave an idle state too early.

Second pin edges and timer pulses are injected mid-warm-up. A design that restarted or queued the window would run longer or gate the clock again.

Mode writes are made while the clock is gated, and the oscillator enables are checked in each state. A design that latched such a write would resume in the wrong speed. A design that lost the earlier running mode across green would resume in the wrong speed or drive the wrong oscillator enable.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int NPINS    = 8,
  parameter int WARM_CYC = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_bits,
  input  logic             tmr_wake_en,
  input  logic             tmr_timeout,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pin_wake_mask,
  output logic             cpu_clk_en,
  output logic             hosc_en,
  output logic             losc_en,
  output logic             lo_clk_sel
);
  localparam int CW = $clog2(WARM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYC - 1);
  localparam logic [1:0] M_FULL  = 2'b00;
  localparam logic [1:0] M_SLEEP = 2'b01;
  localparam logic [1:0] M_SLOW  = 2'b10;
  localparam logic [1:0] M_GREEN = 2'b11;

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_GREEN, ST_WARM} st_t;

  st_t             st;
  logic            slow_q;
  logic [CW-1:0]   cnt;
  logic [NPINS-1:0] sy1, sy2, sy3;
  logic            pin_fall, tmr_wake, wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
      sy3 <= '1;
    end else begin
      sy1 <= pin_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end

  assign pin_fall = |(sy3 & ~sy2 & pin_wake_mask);
  assign tmr_wake = tmr_wake_en & tmr_timeout;
  assign wake = (st == ST_SLEEP && pin_fall) ||
                (st == ST_GREEN && (pin_fall || tmr_wake));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_RUN;
      slow_q <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        ST_RUN:
          if (mode_wr)
            case (mode_bits)
              M_FULL:  slow_q <= 1'b0;
              M_SLOW:  slow_q <= 1'b1;
              M_SLEEP: st <= ST_SLEEP;
              M_GREEN: st <= ST_GREEN;
              default: ;
            endcase
        ST_SLEEP, ST_GREEN:
          if (wake) begin
            st  <= ST_WARM;
            cnt <= '0;
          end
        ST_WARM:
          if (cnt == LAST) st <= ST_RUN;
          else             cnt <= cnt + 1'b1;
        default: st <= ST_RUN;
      endcase
    end

  assign cpu_clk_en = (st == ST_RUN);
  assign losc_en    = (st != ST_SLEEP);
  assign hosc_en    = (st != ST_SLEEP) && !slow_q;
  assign lo_clk_sel = slow_q;

  // R3
  sleep_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_bits == M_SLEEP && cpu_clk_en) |=> (!hosc_en && !losc_en && !cpu_clk_en));

  // R5
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && !pin_fall) |=> (st == ST_SLEEP));

  // R6
  green_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GREEN && !pin_fall && !tmr_wake_en) |=> (st == ST_GREEN));

  // R7
  warm_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> ($past(st) == ST_WARM && $past(cnt) == LAST));

  // R8
  warm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WARM && cnt != LAST) |=> (st == ST_WARM && cnt == CW'($past(cnt) + 1'b1)));

  // R9
  gated_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |=> $stable(lo_clk_sel));
endmodule

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;
  localparam int NP = 8;
  localparam int W  = 2048;

  logic clk = 1'b0, rst_n = 1'b0, mode_wr = 1'b0, tmr_wake_en = 1'b0, tmr_timeout = 1'b0;
  logic [1:0] mode_bits = 2'b00;
  logic [NP-1:0] pin_in = '1, pin_wake_mask = '1;
  logic cpu_clk_en, hosc_en, losc_en, lo_clk_sel;
  int vecs = 0, errs = 0;

  always #10 clk = ~clk;

  pwr_mode_ctl #(.NPINS(NP), .WARM_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .tmr_wake_en(tmr_wake_en), .tmr_timeout(tmr_timeout), .pin_in(pin_in),
    .pin_wake_mask(pin_wake_mask), .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en),
    .losc_en(losc_en), .lo_clk_sel(lo_clk_sel));

  function automatic logic [3:0] outs();
    return {cpu_clk_en, hosc_en, losc_en, lo_clk_sel};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_bits = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_run(output int n);
    n = 0;
    for (int i = 0; i < W + 40; i++) begin
      @(negedge clk); n++;
      if (cpu_clk_en) break;
    end
  endtask

  task automatic pin_wake(int p, output int n);
    @(negedge clk); pin_in[p] = 1'b0;
    wait_run(n);
    pin_in[p] = 1'b1;
    idle(4);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", outs(), 4'b1110);
  endtask

  task automatic t_modes();
    wr_mode(2'b10);
    chk("R2 slow outputs", outs(), 4'b1011);
    wr_mode(2'b00);
    chk("R2 full outputs", outs(), 4'b1110);
  endtask

  task automatic t_sleep_pin();
    int n;
    wr_mode(2'b01);
    chk("R3 sleep outputs", outs(), 4'b0000);
    tmr_wake_en = 1'b1;
    @(negedge clk); tmr_timeout = 1'b1;
    @(negedge clk); tmr_timeout = 1'b0;
    idle(8);
    chk("R5 timer ignored in sleep", outs(), 4'b0000);
    tmr_wake_en = 1'b0;
    @(negedge clk); pin_in[2] = 1'b0;
    idle(3);
    chk("R7 warm outputs from full", outs(), 4'b0110);
    wait_run(n);
    chk("R7 pin wake latency", n + 3, W + 3);
    chk("R7 resumed full", outs(), 4'b1110);
    pin_in[2] = 1'b1;
    idle(4);
  endtask

  task automatic t_masked();
    int n;
    wr_mode(2'b01);
    pin_wake_mask = 8'hF7;
    @(negedge clk); pin_in[3] = 1'b0;
    idle(10);
    chk("R10 masked pin ignored", outs(), 4'b0000);
    pin_in[3] = 1'b1;
    idle(10);
    chk("R10 rising edge ignored", outs(), 4'b0000);
    pin_wake(0, n);
    chk("R5 enabled pin wakes", n, W + 3);
    pin_wake_mask = '1;
  endtask

  task automatic t_green_timer();
    int n;
    wr_mode(2'b10);
    wr_mode(2'b11);
    chk("R4 green from slow", outs(), 4'b0011);
    tmr_wake_en = 1'b0;
    @(negedge clk); tmr_timeout = 1'b1;
    @(negedge clk); tmr_timeout = 1'b0;
    idle(8);
    chk("R6 timer without enable ignored", outs(), 4'b0011);
    tmr_wake_en = 1'b1;
    @(negedge clk); tmr_timeout = 1'b1;
    @(negedge clk); tmr_timeout = 1'b0;
    chk("R7 warm outputs from slow", outs(), 4'b0011);
    wait_run(n);
    chk("R6 timer wake latency", n + 1, W + 1);
    chk("R7 resumed slow", outs(), 4'b1011);
    tmr_wake_en = 1'b0;
  endtask

  task automatic t_green_gated_write();
    int n;
    wr_mode(2'b00);
    wr_mode(2'b11);
    chk("R4 green from full", outs(), 4'b0110);
    wr_mode(2'b10);
    wr_mode(2'b01);
    chk("R9 write in green ignored", outs(), 4'b0110);
    pin_wake(5, n);
    chk("R6 pin wakes green", n, W + 3);
    chk("R9 resumed full not slow", outs(), 4'b1110);
  endtask

  task automatic t_warm_ignore();
    int n;
    wr_mode(2'b11);
    tmr_wake_en = 1'b1;
    @(negedge clk); tmr_timeout = 1'b1;
    @(negedge clk); tmr_timeout = 1'b0;
    n = 1;
    for (int i = 0; i < W + 40; i++) begin
      if (i == 100) pin_in[1] = 1'b0;
      if (i == 300) pin_in[1] = 1'b1;
      if (i == 500) tmr_timeout = 1'b1;
      if (i == 501) tmr_timeout = 1'b0;
      if (i == 700) mode_wr = 1'b1;
      if (i == 701) mode_wr = 1'b0;
      mode_bits = 2'b10;
      if (cpu_clk_en) break;
      @(negedge clk); n++;
    end
    chk("R8 window not extended", n, W + 1);
    idle(50);
    chk("R8 no queued wake", outs(), 4'b1110);
    tmr_wake_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_sleep_pin();
    t_masked();
    t_green_timer();
    t_green_gated_write();
    t_warm_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule